// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Page Status Tracking

This block caches recent virtual-to-physical page translations in a small, fully associative store. Every valid entry is compared against the virtual page of a request in parallel. On a match with sufficient permission, the physical address is produced combinationally in the same cycle. It is formed from the stored physical page joined to the untouched 12-bit page offset. When no valid entry matches, the block raises a miss. An external page-table walker then supplies a refill entry, and the requester retries.

Each entry keeps a reference bit and a dirty bit, and the block updates both itself. The first store to a clean page raises a dirty-update request so the in-memory page table can be brought in line. An access that the entry's permission bits forbid is reported as a protection fault instead of a hit. Refill placement prefers a free entry. When no entry is free, refill replaces the least recently used entry, where both hits and refills count as use. A flush input empties the whole buffer in one cycle.

Top module: `tlb_fa`

## Requirements
- R1: When a request hits, `paddr_o` in the same cycle equals the stored 18-bit physical page in bits [29:12] and the request's address bits [11:0] in bits [11:0].
- R2: A request whose virtual page (address bits [31:12]) matches no valid entry asserts `miss_o` in the same cycle. In that case `hit_o` and `prot_fault_o` stay low. At most one of hit, miss and fault is high in any cycle.
- R3: A refill installs its page so that a later request to that page does not miss. A refill whose page is already present overwrites that entry, so no two valid entries ever match the same page.
- R4: A refill of a page not already present is placed in the lowest-numbered invalid entry when one exists. After a flush, 16 refills of distinct pages therefore all stay resident.
- R5: When all entries are valid, a refill of a new page replaces the least recently used entry. Both a hit and a refill make an entry the most recently used. Misses and faults do not change the order.
- R6: `hit_ref_o` shows the matched entry's reference bit as it stands before the current access. A hit sets that bit. A refill clears it.
- R7: A store hit on an entry whose dirty bit is clear asserts `dirty_upd_o` and sets the dirty bit. `hit_dirty_o` shows the dirty bit before the current access.
- R8: Permission bit 0 allows loads and bit 1 allows stores. A matched access without the required bit asserts `prot_fault_o` instead of `hit_o`, and changes neither the reference bit nor the dirty bit.
- R9: `flush_i` clears every valid bit in one cycle, so all requests miss from the next cycle on. A flush takes priority over a refill in the same cycle, which is then dropped.
- R10: In a cycle that carries a refill, a hit leaves the status bits of the matched entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Translation request present |
| req_vaddr_i | input | 32 | Virtual address of request |
| req_store_i | input | 1 | Request is a store (1) or load (0) |
| hit_o | output | 1 | Translation valid and permitted |
| miss_o | output | 1 | No valid entry matches; refill request |
| prot_fault_o | output | 1 | Entry matches but access not permitted |
| dirty_upd_o | output | 1 | First store to a clean page; update page table |
| hit_ref_o | output | 1 | Reference bit of matched entry before access |
| hit_dirty_o | output | 1 | Dirty bit of matched entry before access |
| paddr_o | output | 30 | Physical address, zero unless hit |
| refill_valid_i | input | 1 | Refill entry present |
| refill_vpn_i | input | 20 | Virtual page of refill |
| refill_ppn_i | input | 18 | Physical page of refill |
| refill_perm_i | input | 2 | Permission bits of refill: bit 0 load, bit 1 store |

## Verification
The assertions check on every cycle that hit, miss and fault are mutually exclusive and that no two entries ever match the same page. They also check that a refill prevents a following miss on its page, that a flush stops any match in the next cycle, and that the reference and dirty bits are set after a hit or store hit. Replacement order is visible only through sequences of requests, and so is the placement of refills into free entries after a flush. Both are therefore shown only by the bench's scenarios, together with the exact physical address values and the permission encoding.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int unsigned VPN_W  = 20;
  parameter int unsigned PPN_W  = 18;
  parameter int unsigned OFF_W  = 12;
  parameter int unsigned PERM_W = 2;
  localparam int unsigned VA_W  = VPN_W + OFF_W;
  localparam int unsigned PA_W  = PPN_W + OFF_W;

  // perm[0]: load allowed, perm[1]: store allowed
  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [PERM_W-1:0] perm;
    logic              dirty;
    logic              refd;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  tlb_entry_t       ent_i [N],
  input  logic [VPN_W-1:0] vpn_i,
  output logic [N-1:0]     match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = ent_i[g].valid && (ent_i[g].vpn == vpn_i);
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int unsigned N     = 16,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] lru_idx_o
);
  // age[i][j] = 1: entry i used more recently than entry j
  logic [N-1:0] age [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          age[i][j] <= (i > j);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          if (i == int'(touch_idx_i) && j != i) age[i][j] <= 1'b1;
          else if (j == int'(touch_idx_i))      age[i][j] <= 1'b0;
        end
    end
  end

  always_comb begin
    lru_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if ((age[i] & ~(N'(1) << i)) == '0) lru_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N     = 16,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid_i,
  input  logic [IDX_W-1:0] lru_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  logic             have_free;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
    victim_o = have_free ? free_idx : lru_idx_i;
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic              req_store_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic              prot_fault_o,
  output logic              dirty_upd_o,
  output logic              hit_ref_o,
  output logic              hit_dirty_o,
  output logic [PA_W-1:0]   paddr_o,
  input  logic              refill_valid_i,
  input  logic [VPN_W-1:0]  refill_vpn_i,
  input  logic [PPN_W-1:0]  refill_ppn_i,
  input  logic [PERM_W-1:0] refill_perm_i
);
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES);

  tlb_entry_t             ent [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] match_vec;
  logic [NUM_ENTRIES-1:0] rf_match_vec;
  logic [NUM_ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]       hit_idx, rf_idx, lru_idx, victim_idx, tgt_idx;
  logic                   any_match, rf_present, perm_ok;
  tlb_entry_t             sel;
  logic [VPN_W-1:0]       req_vpn;
  logic                   touch;
  logic [IDX_W-1:0]       touch_idx;

  assign req_vpn = req_vaddr_i[VA_W-1:OFF_W];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_vld
    assign valid_vec[g] = ent[g].valid;
  end

  tlb_match #(.N(NUM_ENTRIES)) u_req_match (
    .ent_i(ent), .vpn_i(req_vpn), .match_o(match_vec)
  );

  tlb_match #(.N(NUM_ENTRIES)) u_rf_match (
    .ent_i(ent), .vpn_i(refill_vpn_i), .match_o(rf_match_vec)
  );

  // one-hot to index (matches are unique by construction of refill)
  always_comb begin
    hit_idx = '0;
    rf_idx  = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (match_vec[i])    hit_idx = hit_idx | IDX_W'(i);
      if (rf_match_vec[i]) rf_idx  = rf_idx  | IDX_W'(i);
    end
  end

  assign any_match  = |match_vec;
  assign rf_present = |rf_match_vec;
  assign sel        = ent[hit_idx];
  assign perm_ok    = req_store_i ? sel.perm[1] : sel.perm[0];

  assign hit_o        = req_valid_i && any_match && perm_ok;
  assign prot_fault_o = req_valid_i && any_match && !perm_ok;
  assign miss_o       = req_valid_i && !any_match;
  assign dirty_upd_o  = hit_o && req_store_i && !sel.dirty;
  assign hit_ref_o    = req_valid_i && any_match && sel.refd;
  assign hit_dirty_o  = req_valid_i && any_match && sel.dirty;
  assign paddr_o      = hit_o ? {sel.ppn, req_vaddr_i[OFF_W-1:0]} : '0;

  tlb_lru #(.N(NUM_ENTRIES)) u_lru (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .touch_i(touch), .touch_idx_i(touch_idx), .lru_idx_o(lru_idx)
  );

  tlb_victim #(.N(NUM_ENTRIES)) u_victim (
    .valid_i(valid_vec), .lru_idx_i(lru_idx), .victim_o(victim_idx)
  );

  assign tgt_idx   = rf_present ? rf_idx : victim_idx;
  assign touch     = !flush_i && (refill_valid_i || hit_o);
  assign touch_idx = refill_valid_i ? tgt_idx : hit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ENTRIES; i++) ent[i] <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < NUM_ENTRIES; i++) ent[i].valid <= 1'b0;
    end else if (refill_valid_i) begin
      ent[tgt_idx] <= '{valid: 1'b1, vpn: refill_vpn_i, ppn: refill_ppn_i,
                        perm: refill_perm_i, dirty: 1'b0, refd: 1'b0};
    end else if (hit_o) begin
      ent[hit_idx].refd <= 1'b1;
      if (req_store_i) ent[hit_idx].dirty <= 1'b1;
    end
  end
endmodule

// File: rtl/tlb_fa_checker.sv
module tlb_fa_checker
  import tlb_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             req_valid_i,
  input logic [VA_W-1:0]  req_vaddr_i,
  input logic             req_store_i,
  input logic             hit_o,
  input logic             miss_o,
  input logic             prot_fault_o,
  input logic             dirty_upd_o,
  input logic             hit_ref_o,
  input logic             hit_dirty_o,
  input logic             refill_valid_i,
  input logic [VPN_W-1:0] refill_vpn_i,
  input logic [N-1:0]     match_vec
);
  logic [VPN_W-1:0] vpn;
  assign vpn = req_vaddr_i[VA_W-1:OFF_W];

  assert_outcome_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_o, miss_o, prot_fault_o}));

  assert_unique_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));

  assert_refill_resident_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_valid_i && !flush_i) |=>
      ((req_valid_i && vpn == $past(refill_vpn_i)) -> !miss_o));

  assert_flush_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!hit_o && !prot_fault_o));

  assert_ref_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !flush_i && !refill_valid_i) |=>
      ((req_valid_i && !miss_o && vpn == $past(vpn)) -> hit_ref_o));

  assert_dirty_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && req_store_i && !flush_i && !refill_valid_i) |=>
      ((req_valid_i && !miss_o && vpn == $past(vpn)) -> hit_dirty_o));

  assert_dirty_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dirty_upd_o |-> (hit_o && req_store_i && !hit_dirty_o));

  assert_fault_no_update_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_fault_o |-> !dirty_upd_o);
endmodule

bind tlb_fa tlb_fa_checker #(.N(NUM_ENTRIES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
  .req_valid_i(req_valid_i), .req_vaddr_i(req_vaddr_i), .req_store_i(req_store_i),
  .hit_o(hit_o), .miss_o(miss_o), .prot_fault_o(prot_fault_o),
  .dirty_upd_o(dirty_upd_o), .hit_ref_o(hit_ref_o), .hit_dirty_o(hit_dirty_o),
  .refill_valid_i(refill_valid_i), .refill_vpn_i(refill_vpn_i),
  .match_vec(match_vec)
);

// File: tb/sim_tlb_fa.sv
module sim_tlb_fa;
  import tlb_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flush = 1'b0;
  logic              req_valid = 1'b0;
  logic [VA_W-1:0]   req_vaddr = '0;
  logic              req_store = 1'b0;
  logic              hit, miss, fault, dupd, href, hdirty;
  logic [PA_W-1:0]   paddr;
  logic              rf_valid = 1'b0;
  logic [VPN_W-1:0]  rf_vpn = '0;
  logic [PPN_W-1:0]  rf_ppn = '0;
  logic [PERM_W-1:0] rf_perm = '0;

  int tests = 0;
  int fails = 0;

  // captured outputs of the last lookup
  logic            r_hit, r_miss, r_fault, r_dupd, r_ref, r_dirty;
  logic [PA_W-1:0] r_paddr;

  always #2 clk = ~clk;

  tlb_fa u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_store_i(req_store),
    .hit_o(hit), .miss_o(miss), .prot_fault_o(fault), .dirty_upd_o(dupd),
    .hit_ref_o(href), .hit_dirty_o(hdirty), .paddr_o(paddr),
    .refill_valid_i(rf_valid), .refill_vpn_i(rf_vpn),
    .refill_ppn_i(rf_ppn), .refill_perm_i(rf_perm)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                        input logic st);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = {vpn, off};
    req_store = st;
    #1;
    r_hit = hit; r_miss = miss; r_fault = fault;
    r_dupd = dupd; r_ref = href; r_dirty = hdirty; r_paddr = paddr;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    req_store = 1'b0;
  endtask

  task automatic refill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                        input logic [PERM_W-1:0] perm, input logic with_flush);
    @(negedge clk);
    rf_valid = 1'b1; rf_vpn = vpn; rf_ppn = ppn; rf_perm = perm;
    flush = with_flush;
    @(posedge clk);
    #1;
    rf_valid = 1'b0;
    flush = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    #1;
    flush = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R2 idle hit", 64'(hit), 64'd0);
    chk("R2 idle miss", 64'(miss), 64'd0);
    lookup(20'h12345, 12'h678, 1'b0);
    chk("R2 empty miss", 64'(r_miss), 64'd1);
    chk("R2 empty hit", 64'(r_hit), 64'd0);
    chk("R2 empty paddr", 64'(r_paddr), 64'd0);
  endtask

  task automatic t_refill_hit();
    lookup(20'hAAAAA, 12'h123, 1'b0);
    chk("R2 pre-refill miss", 64'(r_miss), 64'd1);
    refill(20'hAAAAA, 18'h2BCDE, 2'b11, 1'b0);
    lookup(20'hAAAAA, 12'h123, 1'b0);
    chk("R3 retry hit", 64'(r_hit), 64'd1);
    chk("R1 paddr", 64'(r_paddr), 64'({18'h2BCDE, 12'h123}));
    lookup(20'hAAAAA, 12'hFFF, 1'b0);
    chk("R1 paddr max off", 64'(r_paddr), 64'({18'h2BCDE, 12'hFFF}));
    lookup(20'hAAAAA, 12'h000, 1'b0);
    chk("R1 paddr zero off", 64'(r_paddr), 64'({18'h2BCDE, 12'h000}));
    refill(20'hAAAAA, 18'h01111, 2'b11, 1'b0);
    lookup(20'hAAAAA, 12'h456, 1'b0);
    chk("R3 overwrite hit", 64'(r_hit), 64'd1);
    chk("R3 overwrite paddr", 64'(r_paddr), 64'({18'h01111, 12'h456}));
  endtask

  task automatic t_ref();
    refill(20'h0BBBB, 18'h00B0B, 2'b01, 1'b0);
    lookup(20'h0BBBB, 12'h010, 1'b0);
    chk("R6 ref clear after refill", 64'(r_ref), 64'd0);
    lookup(20'h0BBBB, 12'h010, 1'b0);
    chk("R6 ref set after hit", 64'(r_ref), 64'd1);
  endtask

  task automatic t_dirty();
    refill(20'h0CCCC, 18'h00C0C, 2'b11, 1'b0);
    lookup(20'h0CCCC, 12'h020, 1'b1);
    chk("R7 first store hit", 64'(r_hit), 64'd1);
    chk("R7 first store dirty_upd", 64'(r_dupd), 64'd1);
    chk("R7 dirty before", 64'(r_dirty), 64'd0);
    lookup(20'h0CCCC, 12'h024, 1'b1);
    chk("R7 second store no dirty_upd", 64'(r_dupd), 64'd0);
    chk("R7 dirty set", 64'(r_dirty), 64'd1);
    lookup(20'h0CCCC, 12'h028, 1'b0);
    chk("R7 load no dirty_upd", 64'(r_dupd), 64'd0);
  endtask

  task automatic t_hit_during_refill();
    refill(20'h0EEEE, 18'h00E0E, 2'b11, 1'b0);
    // store hit to 0EEEE while refilling an unrelated page
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {20'h0EEEE, 12'h000}; req_store = 1'b1;
    rf_valid = 1'b1; rf_vpn = 20'h0EEEF; rf_ppn = 18'h00E0F; rf_perm = 2'b11;
    #1;
    chk("R10 hit during refill", 64'(hit), 64'd1);
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_store = 1'b0; rf_valid = 1'b0;
    lookup(20'h0EEEE, 12'h000, 1'b0);
    chk("R10 dirty unchanged", 64'(r_dirty), 64'd0);
    chk("R10 ref unchanged", 64'(r_ref), 64'd0);
  endtask

  task automatic t_prot();
    refill(20'h0DDDD, 18'h00D0D, 2'b01, 1'b0);
    lookup(20'h0DDDD, 12'h030, 1'b1);
    chk("R8 store on read-only fault", 64'(r_fault), 64'd1);
    chk("R8 store on read-only no hit", 64'(r_hit), 64'd0);
    chk("R8 fault no dirty_upd", 64'(r_dupd), 64'd0);
    lookup(20'h0DDDD, 12'h030, 1'b0);
    chk("R8 load permitted", 64'(r_hit), 64'd1);
    chk("R8 fault left dirty clear", 64'(r_dirty), 64'd0);
    chk("R8 fault left ref clear", 64'(r_ref), 64'd0);
    refill(20'h0D0D0, 18'h00D00, 2'b10, 1'b0);
    lookup(20'h0D0D0, 12'h000, 1'b0);
    chk("R8 load on write-only fault", 64'(r_fault), 64'd1);
    lookup(20'h0D0D0, 12'h000, 1'b1);
    chk("R8 store on write-only hit", 64'(r_hit), 64'd1);
  endtask

  task automatic t_flush();
    do_flush();
    lookup(20'hAAAAA, 12'h000, 1'b0);
    chk("R9 flushed A miss", 64'(r_miss), 64'd1);
    lookup(20'h0CCCC, 12'h000, 1'b0);
    chk("R9 flushed C miss", 64'(r_miss), 64'd1);
    refill(20'h0FFFF, 18'h00F0F, 2'b11, 1'b1);
    lookup(20'h0FFFF, 12'h000, 1'b0);
    chk("R9 flush beats refill", 64'(r_miss), 64'd1);
  endtask

  task automatic t_lru();
    do_flush();
    for (int i = 0; i < 16; i++)
      refill(20'h10000 + 20'(i), 18'h01000 + 18'(i), 2'b11, 1'b0);
    for (int i = 0; i < 16; i++) begin
      lookup(20'h10000 + 20'(i), 12'h000, 1'b0);
      chk("R4 all refills resident", 64'(r_hit), 64'd1);
    end
    // order LRU..MRU now V0..V15; touch V0 -> V1 is LRU
    lookup(20'h10000, 12'h000, 1'b0);
    refill(20'h20000, 18'h02000, 2'b11, 1'b0);
    lookup(20'h10001, 12'h000, 1'b0);
    chk("R5 LRU evicted", 64'(r_miss), 64'd1);
    lookup(20'h10000, 12'h000, 1'b0);
    chk("R5 touched kept", 64'(r_hit), 64'd1);
    lookup(20'h20000, 12'h000, 1'b0);
    chk("R5 new entry hit", 64'(r_hit), 64'd1);
    lookup(20'h10002, 12'h000, 1'b0);
    chk("R5 other kept", 64'(r_hit), 64'd1);
    // order now V3..V15, V0, W, V2
    refill(20'h20001, 18'h02001, 2'b11, 1'b0);
    lookup(20'h10003, 12'h000, 1'b0);
    chk("R5 next LRU evicted", 64'(r_miss), 64'd1);
    lookup(20'h10004, 12'h000, 1'b0);
    chk("R5 V4 kept", 64'(r_hit), 64'd1);
  endtask

  bit done = 1'b0;

  initial begin
    #(4 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_refill_hit();
    t_ref();
    t_dirty();
    t_hit_during_refill();
    t_prot();
    t_flush();
    t_lru();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule